// File: doc/BRIEF.md
# SPI Interrupt Status Controller

This block gathers the interrupt causes of an SPI master into one status word and drives a single level interrupt line. Three causes are events: transmit underflow, receive overflow and mode fault. Each arrives as a one-cycle pulse and is held until software clears it. Four causes are levels: receive full, receive above threshold, transmit full and transmit below threshold. These are derived afresh each cycle from the FIFO occupancy counts and two programmable thresholds. An interrupt mask gates the status word onto the interrupt line. Software can set mask bits only through an enable register and clear them only through a disable register.

The register port is plain control. It has no valid/ready pair and applies back-pressure to nothing: every access is taken in the cycle it is presented. Read data is combinational and valid in any cycle with `reg_rd_i` high. Writes, and the clearing side effect of a status read, take effect at the next rising clock edge. While `lin_mode_i` is high, the controller is being used for direct memory-mapped flash reads. In that mode the status word is frozen, and only software clears still act on it.

Word offsets: 0 status, 1 mask enable, 2 mask disable, 3 mask, 4 transmit threshold, 5 receive threshold. Offsets 6 and 7 read as zero and ignore writes.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Status bit positions are fixed. Bit 0 is receive overflow, bit 1 mode fault, bit 2 transmit below threshold, bit 3 transmit full, bit 4 receive at or above threshold, bit 5 receive full and bit 6 transmit underflow. A status read returns zero in bits 31:7.
- R2: An event pulse sets its status bit at the next edge. The bit then stays set through any number of idle cycles until it is cleared.
- R3: Bit 4 is high when the receive count is greater than or equal to the receive threshold. Bit 2 is high when the transmit count is strictly less than the transmit threshold. Bits 5 and 3 are high when the receive count or the transmit count equals FIFO_DEPTH. None of these four bits is latched.
- R4: A status read returns the level bits of the current counts in the same cycle. At the following edge it clears every held status bit.
- R5: A write to offset 0 clears exactly the event bits written with 1. The other event bits are left as they were.
- R6: A write to offset 1 ORs bits 6:0 into the mask, and a write to offset 2 clears those bits. A write to offset 3 has no effect. Reads of offsets 1 and 2 return 0, and a read of offset 3 returns the mask.
- R7: `irq_o` is high exactly when some bit is set in both the mask and the status word.
- R8: After reset the mask and the event bits are 0, and both thresholds read 1.
- R9: While `lin_mode_i` is high, event pulses and count changes leave the status word unchanged.
- R10: An event pulse in the same cycle as a status read or a write-1-to-clear of its bit leaves that bit set.
- R11: Writes to offsets 4 and 5 load the low CNT_W bits into the transmit and receive thresholds, and reads return those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin_mode_i | input | 1 | Linear read mode; freezes the status word |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| ev_tx_underflow_i | input | 1 | One-cycle transmit underflow pulse |
| ev_rx_overflow_i | input | 1 | One-cycle receive overflow pulse |
| ev_mode_fault_i | input | 1 | One-cycle mode fault pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Word offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid while reg_rd_i is high |
| irq_o | output | 1 | Level interrupt output |

## Verification
Three pairs of functions can land in the same cycle. An event pulse can arrive with a status read that clears the word, or with a write-1-to-clear of its own bit. A FIFO count can change in the very cycle of a status read. The bench drives each coincidence directly. It then reads the status again and judges that the event bit survived while the untouched bits were cleared. It also judges that the level bits in the clearing read already reflected the new count. Random stimulus with rare pulses and frequent reads produces further coincidences, including ones during the freeze, and each read is compared with a bench model built from the requirements.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ST_W   = 7;
  localparam int ADDR_W = 3;

  localparam int B_RXOVF  = 0;
  localparam int B_MODEF  = 1;
  localparam int B_TXLOW  = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXHIGH = 4;
  localparam int B_RXFULL = 5;
  localparam int B_TXUNF  = 6;

  localparam logic [ST_W-1:0] STICKY_MASK =
    (ST_W'(1) << B_TXUNF) | (ST_W'(1) << B_MODEF) | (ST_W'(1) << B_RXOVF);

  localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIS   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TXTHR = 3'd4;
  localparam logic [ADDR_W-1:0] A_RXTHR = 3'd5;

  typedef struct packed {
    logic stat_rd;
    logic stat_wr;
    logic en_wr;
    logic dis_wr;
    logic txthr_wr;
    logic rxthr_wr;
  } reg_strb_t;
endpackage

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ST_W-1:0]   mask_o,
  output logic [CNT_W-1:0]  tx_thr_o,
  output logic [CNT_W-1:0]  rx_thr_o,
  output logic [ST_W-1:0]   clr_o
);
  reg_strb_t       strb;
  logic [ST_W-1:0] mask_q;
  logic [CNT_W-1:0] tx_thr_q, rx_thr_q;

  always_comb begin
    strb          = '0;
    strb.stat_rd  = rd_i && (addr_i == A_STAT);
    strb.stat_wr  = wr_i && (addr_i == A_STAT);
    strb.en_wr    = wr_i && (addr_i == A_EN);
    strb.dis_wr   = wr_i && (addr_i == A_DIS);
    strb.txthr_wr = wr_i && (addr_i == A_TXTHR);
    strb.rxthr_wr = wr_i && (addr_i == A_RXTHR);
  end

  always_comb begin
    clr_o = '0;
    if (strb.stat_rd) clr_o = '1;
    if (strb.stat_wr) clr_o = clr_o | wdata_i[ST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (strb.en_wr) begin
      mask_q <= mask_q | wdata_i[ST_W-1:0];
    end else if (strb.dis_wr) begin
      mask_q <= mask_q & ~wdata_i[ST_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= CNT_W'(1);
      rx_thr_q <= CNT_W'(1);
    end else begin
      if (strb.txthr_wr) tx_thr_q <= wdata_i[CNT_W-1:0];
      if (strb.rxthr_wr) rx_thr_q <= wdata_i[CNT_W-1:0];
    end
  end

  localparam int USED_W = (ST_W > CNT_W) ? ST_W : CNT_W;
  generate
    if (DATA_W > USED_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:USED_W];
    end
  endgenerate

  assign mask_o   = mask_q;
  assign tx_thr_o = tx_thr_q;
  assign rx_thr_o = rx_thr_q;
endmodule

// File: rtl/spi_irq_levels.sv
module spi_irq_levels
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 6
) (
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_thr_i,
  input  logic [CNT_W-1:0] rx_thr_i,
  output logic [ST_W-1:0]  lvl_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  always_comb begin
    lvl_o           = '0;
    lvl_o[B_RXFULL] = (rx_count_i == FULL_CNT);
    lvl_o[B_RXHIGH] = (rx_count_i >= rx_thr_i);
    lvl_o[B_TXFULL] = (tx_count_i == FULL_CNT);
    lvl_o[B_TXLOW]  = (tx_count_i <  tx_thr_i);
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            freeze_i,
  input  logic [ST_W-1:0] src_i,
  input  logic [ST_W-1:0] clr_i,
  output logic [ST_W-1:0] vis_o
);
  logic [ST_W-1:0] stat_q, stat_d;

  generate
    for (genvar i = 0; i < ST_W; i++) begin : g_bit
      if (STICKY_MASK[i]) begin : g_evt
        always_comb begin
          if (freeze_i) stat_d[i] = stat_q[i] & ~clr_i[i];
          else          stat_d[i] = (stat_q[i] & ~clr_i[i]) | src_i[i];
        end
        assign vis_o[i] = stat_q[i];
      end else begin : g_lvl
        always_comb begin
          if (freeze_i) stat_d[i] = stat_q[i] & ~clr_i[i];
          else          stat_d[i] = src_i[i];
        end
        assign vis_o[i] = freeze_i ? stat_q[i] : src_i[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int DATA_W     = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lin_mode_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              ev_tx_underflow_i,
  input  logic              ev_rx_overflow_i,
  input  logic              ev_mode_fault_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [ST_W-1:0]  mask_q, clr, lvl, evv, stat_vis;
  logic [CNT_W-1:0] tx_thr, rx_thr;

  spi_irq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .mask_o(mask_q),
    .tx_thr_o(tx_thr), .rx_thr_o(rx_thr), .clr_o(clr)
  );

  spi_irq_levels #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_lvl (
    .tx_count_i(tx_count_i), .rx_count_i(rx_count_i),
    .tx_thr_i(tx_thr), .rx_thr_i(rx_thr), .lvl_o(lvl)
  );

  always_comb begin
    evv          = '0;
    evv[B_TXUNF] = ev_tx_underflow_i;
    evv[B_MODEF] = ev_mode_fault_i;
    evv[B_RXOVF] = ev_rx_overflow_i;
  end

  spi_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .freeze_i(lin_mode_i),
    .src_i(lvl | evv), .clr_i(clr), .vis_o(stat_vis)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_STAT:  reg_rdata_o = DATA_W'(stat_vis);
      A_MASK:  reg_rdata_o = DATA_W'(mask_q);
      A_TXTHR: reg_rdata_o = DATA_W'(tx_thr);
      A_RXTHR: reg_rdata_o = DATA_W'(rx_thr);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(mask_q & stat_vis);
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lin_mode_i,
  input logic              ev_tx_underflow_i,
  input logic              ev_rx_overflow_i,
  input logic              ev_mode_fault_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [ST_W-1:0]   stat_vis,
  input logic [ST_W-1:0]   mask_q
);
  logic stat_rd, stat_wr, ev_any, mask_wr;
  assign stat_rd = reg_rd_i && (reg_addr_i == A_STAT);
  assign stat_wr = reg_wr_i && (reg_addr_i == A_STAT);
  assign ev_any  = ev_tx_underflow_i | ev_rx_overflow_i | ev_mode_fault_i;
  assign mask_wr = reg_wr_i && ((reg_addr_i == A_EN) || (reg_addr_i == A_DIS));

  // R1: only bits 6:0 exist in a status read
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (reg_rdata_o[DATA_W-1:ST_W] == '0));

  // R2: an event bit holds while nothing clears it
  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vis[B_TXUNF] && !stat_rd && !(stat_wr && reg_wdata_i[B_TXUNF]))
    |=> stat_vis[B_TXUNF]);

  // R4: a read clears every event bit when no event arrives
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev_any) |=> ((stat_vis & STICKY_MASK) == '0));

  // R6: the mask changes only through enable and disable
  p_mask_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  // R7: nothing enabled means no interrupt
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  // R9: frozen status holds when software does not touch it
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_mode_i && !stat_rd && !stat_wr) ##1 lin_mode_i |-> $stable(stat_vis));

  // R10: an event wins over a coincident clear
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_underflow_i && !lin_mode_i) |=> stat_vis[B_TXUNF]);
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lin_mode_i(lin_mode_i),
  .ev_tx_underflow_i(ev_tx_underflow_i), .ev_rx_overflow_i(ev_rx_overflow_i),
  .ev_mode_fault_i(ev_mode_fault_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .irq_o(irq_o), .stat_vis(stat_vis), .mask_q(mask_q)
);

// File: tb/spi_irq_ctrl_tb.sv
module spi_irq_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int CW    = 6;
  localparam logic [6:0] STK = 7'b1000011;

  logic clk = 0, rst_n = 0;
  logic lin = 0;
  logic [CW-1:0] txc = '0, rxc = '0;
  logic e_unf = 0, e_ovf = 0, e_mf = 0;
  logic wr = 0, rd = 0;
  logic [2:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [6:0] m_q = '0, m_mask = '0;
  logic [CW-1:0] m_txthr = CW'(1), m_rxthr = CW'(1);

  always #(CLK_P/2) clk = ~clk;

  spi_irq_ctrl #(.FIFO_DEPTH(DEPTH), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .lin_mode_i(lin), .tx_count_i(txc),
    .rx_count_i(rxc), .ev_tx_underflow_i(e_unf), .ev_rx_overflow_i(e_ovf),
    .ev_mode_fault_i(e_mf), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [6:0] live_lvl();
    logic [6:0] v = '0;
    v[5] = (rxc == CW'(DEPTH));
    v[4] = (rxc >= m_rxthr);
    v[3] = (txc == CW'(DEPTH));
    v[2] = (txc <  m_txthr);
    return v;
  endfunction

  function automatic logic [6:0] exp_vis();
    return lin ? m_q : ((m_q & STK) | live_lvl());
  endfunction

  function automatic logic [31:0] exp_rd();
    case (addr)
      3'd0: return {25'd0, exp_vis()};
      3'd3: return {25'd0, m_mask};
      3'd4: return {26'd0, m_txthr};
      3'd5: return {26'd0, m_rxthr};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input logic [2:0] ev, input string tag);
    logic [6:0] clr, evv, lv;
    @(negedge clk);
    rd = r; wr = w; addr = a; wd = d;
    {e_unf, e_mf, e_ovf} = ev;
    #1;
    check("R7", {31'd0, irq}, {31'd0, |(m_mask & exp_vis())});
    if (r) check(tag, rdata, exp_rd());
    @(posedge clk);
    lv  = live_lvl();
    clr = ((r && a == 3'd0) ? 7'h7F : 7'h00) | ((w && a == 3'd0) ? d[6:0] : 7'h00);
    evv = {ev[2], 4'b0000, ev[1], ev[0]};
    if (!lin) m_q = (((m_q & ~clr) | evv) & STK) | lv;
    else      m_q = m_q & ~clr;
    if (w && a == 3'd1) m_mask = m_mask | d[6:0];
    if (w && a == 3'd2) m_mask = m_mask & ~d[6:0];
    if (w && a == 3'd4) m_txthr = d[CW-1:0];
    if (w && a == 3'd5) m_rxthr = d[CW-1:0];
    #1;
    {rd, wr, e_unf, e_mf, e_ovf} = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, 3'b000, tag);
  endtask
  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    step(1'b0, 1'b1, a, d, 3'b000, "WR");
  endtask
  task automatic idle(input logic [2:0] ev);
    step(1'b0, 1'b0, 3'd0, 32'd0, ev, "IDLE");
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R8: reset values, checked against literals
    @(negedge clk); addr = 3'd3; rd = 1; #1; check("R8", rdata, 32'd0);
    addr = 3'd4; #1; check("R8", rdata, 32'd1);
    addr = 3'd5; #1; check("R8", rdata, 32'd1);
    addr = 3'd0; #1; check("R8", rdata, 32'h04);
    rd = 0;

    // R1 and R2: each event lands on its bit and holds
    idle(3'b100); idle(3'b000); idle(3'b000);
    rd_reg(3'd0, "R1");
    idle(3'b010); rd_reg(3'd0, "R1");
    idle(3'b001); idle(3'b000); rd_reg(3'd0, "R2");
    // R5: clear only bit 6 of three held bits
    idle(3'b111);
    wr_reg(3'd0, 32'h40);
    rd_reg(3'd0, "R5");
    rd_reg(3'd0, "R4");

    // R3: threshold boundaries
    wr_reg(3'd5, 32'd5); wr_reg(3'd4, 32'd3);
    rxc = 6'd4; txc = 6'd3; rd_reg(3'd0, "R3");
    rxc = 6'd5; txc = 6'd2; rd_reg(3'd0, "R3");
    rxc = 6'd32; txc = 6'd32; rd_reg(3'd0, "R3");
    // R11: thresholds read back
    rd_reg(3'd4, "R11"); rd_reg(3'd5, "R11");

    // R4: count change in the read cycle itself
    rxc = 6'd0; rd_reg(3'd0, "R4");

    // R10: event with a clearing read and with write-1-to-clear
    step(1'b1, 1'b0, 3'd0, 32'd0, 3'b100, "R4");
    rd_reg(3'd0, "R10");
    idle(3'b001);
    step(1'b0, 1'b1, 3'd0, 32'h01, 3'b001, "R10");
    rd_reg(3'd0, "R10");

    // R6: mask only via enable/disable
    wr_reg(3'd1, 32'h54); rd_reg(3'd3, "R6");
    wr_reg(3'd2, 32'h10); rd_reg(3'd3, "R6");
    wr_reg(3'd3, 32'h7F); rd_reg(3'd3, "R6");
    rd_reg(3'd1, "R6"); rd_reg(3'd2, "R6");
    txc = 6'd0; rd_reg(3'd0, "R7");

    // R9: freeze
    idle(3'b000); lin = 1;
    idle(3'b111); rxc = 6'd32; txc = 6'd10; idle(3'b000);
    rd_reg(3'd3, "R9");
    step(1'b0, 1'b0, 3'd0, 32'd0, 3'b000, "R9");
    rd_reg(3'd0, "R9"); rd_reg(3'd0, "R9");
    lin = 0; rd_reg(3'd0, "R9");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] a, ev;
      logic [31:0] d;
      int op;
      if ($urandom_range(0, 9) == 0) txc = CW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 9) == 0) rxc = CW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 39) == 0) lin = ~lin;
      ev = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
      a  = 3'($urandom);
      d  = $urandom;
      if (a >= 3'd4) d = 32'($urandom_range(0, DEPTH));
      op = $urandom_range(0, 2);
      step(op == 0, op == 1, a, d, ev, "R4");
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule